// File: doc/BRIEF.md
# Initiator Response Timeout and Transaction-ID Checker

This block watches the requests that an initiator sends on a multi-channel serial link between processors. Each channel can have one request in flight. When a request is accepted, the channel stores its 3-bit transaction ID and starts counting cycles. If the channel's programmed limit runs out before a response or acknowledge comes back on that channel, a sticky timeout flag is set for the channel.

When a response does come back, its header is always passed on, even if it is late. The 3-bit ID in the top bits of the header is compared with the ID stored for the channel, and a mismatch sets a sticky ID-error flag. Software reads the flags to decide whether to keep the data.

Each flag is cleared by a write-one-to-clear strobe. A single registered interrupt is raised while any flag is set whose per-channel enable is on. A module enable gates the acceptance of new requests and is low after reset.

Top module: `resp_timeout_guard`

## Requirements
- R1: A request is issued in cycle 0 on a channel with limit L (L > 0). If no response arrives on that channel in cycles 1 to L, the channel's timeout flag reads 1 from cycle L+1 and stays set. If a response arrives in any of cycles 1 to L, the flag is never set by that request.
- R2: A limit of 0 disables the timeout check on that channel, so the timeout flag is never set, however long the response takes.
- R3: Every response is forwarded one cycle after it is presented, with its header and channel unchanged. This includes a response that arrives after its channel has timed out and a response on a channel with nothing outstanding.
- R4: The transaction ID is header bits 15 to 13. A response on a channel with an outstanding request whose ID differs from the stored ID sets that channel's ID-error flag, visible one cycle later. A response on a channel with nothing outstanding is not checked.
- R5: While the enable input is 0, requests are ignored. They start no timer and store no ID.
- R6: A request to a channel that already has one outstanding is ignored. The stored ID is kept and the counter is not restarted.
- R7: A 1 on a channel's clear strobe for a flag clears that flag one cycle later and leaves all other flags unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: The interrupt output is 1 one cycle after any flag is set whose per-channel enable bit (timeout or ID) is 1. It is 0 one cycle after no such flag remains.
- R9: After reset, all flags, the interrupt and the forwarded-valid output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; 0 blocks new requests |
| req_valid | input | 1 | Request-issued strobe |
| req_ch | input | CH_W | Channel of the issued request |
| req_id | input | ID_W | Transaction ID of the issued request |
| rsp_valid | input | 1 | Response or acknowledge strobe |
| rsp_ch | input | CH_W | Channel of the response |
| rsp_hdr | input | HDR_W | Response header; ID in the top ID_W bits |
| tmo_limit | input | NUM_CH*CNT_W | Per-channel timeout limits, channel n at bits n*CNT_W upward |
| tmo_ie | input | NUM_CH | Per-channel timeout interrupt enable |
| ide_ie | input | NUM_CH | Per-channel ID-error interrupt enable |
| clr_tmo | input | NUM_CH | Write-one-to-clear strobes for the timeout flags |
| clr_ide | input | NUM_CH | Write-one-to-clear strobes for the ID-error flags |
| tmo_flag | output | NUM_CH | Sticky timeout flags |
| ide_flag | output | NUM_CH | Sticky ID-error flags |
| irq | output | 1 | Registered error interrupt |
| fwd_valid | output | 1 | Forwarded response valid |
| fwd_ch | output | CH_W | Forwarded response channel |
| fwd_hdr | output | HDR_W | Forwarded response header |

## Verification
The assertions assume that the inputs are sampled on the clock and that the limits are held steady while a request on their channel is outstanding. They also assume that reset is applied before the first checked edge. The bench drives every input on the falling edge and changes a channel's limit only while that channel is idle. It applies reset for several cycles before any traffic. Responses are timed against the request cycle, so that both sides of the L-cycle window and the late-delivery case are hit exactly.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

  // Per-channel life cycle of one outstanding request.
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,  // nothing outstanding
    CH_WAIT = 2'd1,  // counting towards the limit
    CH_LATE = 2'd2   // limit passed, still awaiting the response
  } ch_state_e;

  // Increment that holds at the all-ones value.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] top;
    top = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= top) ? top : v + 32'd1;
  endfunction

endpackage

// File: rtl/rtw_channel.sv
module rtw_channel #(
  parameter int CNT_W = 16,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [ID_W-1:0]  issue_id,
  input  logic             rsp_hit,
  input  logic [ID_W-1:0]  rsp_id,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr_tmo,
  input  logic             clr_ide,
  output logic             busy,
  output logic             tmo_flag,
  output logic             ide_flag
);
  import rtw_pkg::*;

  ch_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [ID_W-1:0]  id_q;
  logic             tmo_set;
  logic             ide_set;
  logic [31:0]      cnt_ext;
  logic [31:0]      cnt_inc;

  assign cnt_ext = 32'(cnt);
  assign cnt_inc = sat_inc(cnt_ext, CNT_W);

  // A response in the same cycle as the limit is reached counts as on time.
  assign tmo_set = (state == CH_WAIT) && !rsp_hit &&
                   (limit != '0) && (cnt == limit);
  assign ide_set = (state != CH_IDLE) && rsp_hit && (rsp_id != id_q);
  assign busy    = (state != CH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CH_IDLE;
      cnt   <= '0;
      id_q  <= '0;
    end else begin
      unique case (state)
        CH_IDLE: begin
          if (issue) begin
            state <= CH_WAIT;
            cnt   <= CNT_W'(1);
            id_q  <= issue_id;
          end
        end
        CH_WAIT: begin
          if (rsp_hit)      state <= CH_IDLE;
          else if (tmo_set) state <= CH_LATE;
          else              cnt   <= cnt_inc[CNT_W-1:0];
        end
        CH_LATE: begin
          if (rsp_hit) state <= CH_IDLE;
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  // Sticky flags: a set has priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_flag <= 1'b0;
      ide_flag <= 1'b0;
    end else begin
      tmo_flag <= tmo_set | (tmo_flag & ~clr_tmo);
      ide_flag <= ide_set | (ide_flag & ~clr_ide);
    end
  end

endmodule

// File: rtl/rtw_fwd.sv
module rtw_fwd #(
  parameter int CH_W  = 2,
  parameter int HDR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_ch,
  input  logic [HDR_W-1:0] in_hdr,
  output logic             out_valid,
  output logic [CH_W-1:0]  out_ch,
  output logic [HDR_W-1:0] out_hdr
);
  // Every response is passed on unconditionally, late or not.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_hdr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch  <= in_ch;
        out_hdr <= in_hdr;
      end
    end
  end
endmodule

// File: rtl/rtw_irq.sv
module rtw_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tmo_flag,
  input  logic [NUM_CH-1:0] ide_flag,
  input  logic [NUM_CH-1:0] tmo_ie,
  input  logic [NUM_CH-1:0] ide_ie,
  output logic              irq
);
  logic [NUM_CH-1:0] pend;

  assign pend = (tmo_flag & tmo_ie) | (ide_flag & ide_ie);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end
endmodule

// File: rtl/resp_timeout_guard.sv
module resp_timeout_guard #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ID_W   = 3,
  parameter int HDR_W  = 16,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    req_valid,
  input  logic [CH_W-1:0]         req_ch,
  input  logic [ID_W-1:0]         req_id,
  input  logic                    rsp_valid,
  input  logic [CH_W-1:0]         rsp_ch,
  input  logic [HDR_W-1:0]        rsp_hdr,
  input  logic [NUM_CH*CNT_W-1:0] tmo_limit,
  input  logic [NUM_CH-1:0]       tmo_ie,
  input  logic [NUM_CH-1:0]       ide_ie,
  input  logic [NUM_CH-1:0]       clr_tmo,
  input  logic [NUM_CH-1:0]       clr_ide,
  output logic [NUM_CH-1:0]       tmo_flag,
  output logic [NUM_CH-1:0]       ide_flag,
  output logic                    irq,
  output logic                    fwd_valid,
  output logic [CH_W-1:0]         fwd_ch,
  output logic [HDR_W-1:0]        fwd_hdr
);
  localparam int ID_MSB = HDR_W - 1;

  logic [NUM_CH-1:0] busy;
  logic [ID_W-1:0]   rsp_id;

  assign rsp_id = rsp_hdr[ID_MSB -: ID_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic issue_g;
    logic hit_g;

    assign issue_g = enable && req_valid && (req_ch == CH_W'(g)) && !busy[g];
    assign hit_g   = rsp_valid && (rsp_ch == CH_W'(g));

    rtw_channel #(
      .CNT_W (CNT_W),
      .ID_W  (ID_W)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .issue    (issue_g),
      .issue_id (req_id),
      .rsp_hit  (hit_g),
      .rsp_id   (rsp_id),
      .limit    (tmo_limit[g*CNT_W +: CNT_W]),
      .clr_tmo  (clr_tmo[g]),
      .clr_ide  (clr_ide[g]),
      .busy     (busy[g]),
      .tmo_flag (tmo_flag[g]),
      .ide_flag (ide_flag[g])
    );
  end

  rtw_fwd #(
    .CH_W  (CH_W),
    .HDR_W (HDR_W)
  ) u_fwd (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rsp_valid),
    .in_ch     (rsp_ch),
    .in_hdr    (rsp_hdr),
    .out_valid (fwd_valid),
    .out_ch    (fwd_ch),
    .out_hdr   (fwd_hdr)
  );

  rtw_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tmo_flag (tmo_flag),
    .ide_flag (ide_flag),
    .tmo_ie   (tmo_ie),
    .ide_ie   (ide_ie),
    .irq      (irq)
  );

endmodule

// File: rtl/rtw_checker.sv
module rtw_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int HDR_W  = 16,
  parameter int CH_W   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic                    rsp_valid,
  input logic [CH_W-1:0]         rsp_ch,
  input logic [HDR_W-1:0]        rsp_hdr,
  input logic [NUM_CH*CNT_W-1:0] tmo_limit,
  input logic [NUM_CH-1:0]       clr_tmo,
  input logic [NUM_CH-1:0]       clr_ide,
  input logic [NUM_CH-1:0]       tmo_flag,
  input logic [NUM_CH-1:0]       ide_flag,
  input logic                    irq,
  input logic                    fwd_valid,
  input logic [CH_W-1:0]         fwd_ch,
  input logic [HDR_W-1:0]        fwd_hdr,
  input logic [NUM_CH-1:0]       busy
);

  // R3: each response reappears unchanged one cycle later
  assert_fwd_copy_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (fwd_valid && fwd_hdr == $past(rsp_hdr) && fwd_ch == $past(rsp_ch)));

  assert_fwd_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> !fwd_valid);

  // R8: interrupt only follows a set flag, and drops once none remain
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(tmo_flag | ide_flag) != '0));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ((tmo_flag | ide_flag) == '0) |=> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7: flags hold until cleared
    assert_tmo_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (tmo_flag[i] && !clr_tmo[i]) |=> tmo_flag[i]);

    assert_ide_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (ide_flag[i] && !clr_ide[i]) |=> ide_flag[i]);

    // R2: a zero limit never times out
    assert_zero_limit_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(tmo_flag[i]) |-> ($past(tmo_limit[i*CNT_W +: CNT_W]) != '0));

    // R1: a timed-out channel still awaits its response
    assert_timeout_pending_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(tmo_flag[i]) |-> busy[i]);

    // R4: an ID error comes only from a response on that channel
    assert_ide_source_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(ide_flag[i]) |-> $past(rsp_valid && rsp_ch == CH_W'(i)));

    // R5: no request is taken while disabled
    assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!enable && !busy[i]) |=> !busy[i]);
  end

endmodule

bind resp_timeout_guard rtw_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .HDR_W  (HDR_W),
  .CH_W   (CH_W)
) u_rtw_checker (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .rsp_valid (rsp_valid),
  .rsp_ch    (rsp_ch),
  .rsp_hdr   (rsp_hdr),
  .tmo_limit (tmo_limit),
  .clr_tmo   (clr_tmo),
  .clr_ide   (clr_ide),
  .tmo_flag  (tmo_flag),
  .ide_flag  (ide_flag),
  .irq       (irq),
  .fwd_valid (fwd_valid),
  .fwd_ch    (fwd_ch),
  .fwd_hdr   (fwd_hdr),
  .busy      (busy)
);

// File: tb/test_resp_timeout_guard.sv
`timescale 1ns/1ps
module test_resp_timeout_guard;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ID_W   = 3;
  localparam int HDR_W  = 16;
  localparam int CH_W   = 2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    enable = 1'b0;
  logic                    req_valid = 1'b0;
  logic [CH_W-1:0]         req_ch = '0;
  logic [ID_W-1:0]         req_id = '0;
  logic                    rsp_valid = 1'b0;
  logic [CH_W-1:0]         rsp_ch = '0;
  logic [HDR_W-1:0]        rsp_hdr = '0;
  logic [NUM_CH*CNT_W-1:0] tmo_limit = '0;
  logic [NUM_CH-1:0]       tmo_ie = '0;
  logic [NUM_CH-1:0]       ide_ie = '0;
  logic [NUM_CH-1:0]       clr_tmo = '0;
  logic [NUM_CH-1:0]       clr_ide = '0;
  logic [NUM_CH-1:0]       tmo_flag;
  logic [NUM_CH-1:0]       ide_flag;
  logic                    irq;
  logic                    fwd_valid;
  logic [CH_W-1:0]         fwd_ch;
  logic [HDR_W-1:0]        fwd_hdr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  resp_timeout_guard #(
    .NUM_CH (NUM_CH), .CNT_W (CNT_W), .ID_W (ID_W), .HDR_W (HDR_W), .CH_W (CH_W)
  ) i_resp_timeout_guard (
    .clk (clk), .rst (rst), .enable (enable),
    .req_valid (req_valid), .req_ch (req_ch), .req_id (req_id),
    .rsp_valid (rsp_valid), .rsp_ch (rsp_ch), .rsp_hdr (rsp_hdr),
    .tmo_limit (tmo_limit), .tmo_ie (tmo_ie), .ide_ie (ide_ie),
    .clr_tmo (clr_tmo), .clr_ide (clr_ide),
    .tmo_flag (tmo_flag), .ide_flag (ide_flag), .irq (irq),
    .fwd_valid (fwd_valid), .fwd_ch (fwd_ch), .fwd_hdr (fwd_hdr)
  );

  // Stimulus table: request, response timing and expected flags.
  typedef struct packed {
    logic [1:0]  ch;
    logic [2:0]  id;
    logic [2:0]  rid;
    logic [15:0] lim;
    logic [7:0]  dly;
    logic        etmo;
    logic        eide;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd3, 3'd3, 16'd5, 8'd3,  1'b0, 1'b0},  // R1 in time
    '{2'd1, 3'd5, 3'd2, 16'd5, 8'd5,  1'b0, 1'b1},  // R1 last on-time cycle, R4 mismatch
    '{2'd2, 3'd1, 3'd1, 16'd4, 8'd5,  1'b1, 1'b0},  // R1 first late cycle, R3 late forward
    '{2'd3, 3'd7, 3'd0, 16'd2, 8'd9,  1'b1, 1'b1},  // R1 and R4 together
    '{2'd0, 3'd0, 3'd0, 16'd0, 8'd20, 1'b0, 1'b0},  // R2 zero limit
    '{2'd2, 3'd6, 3'd6, 16'd1, 8'd1,  1'b0, 1'b0},  // R1 minimum limit, on time
    '{2'd1, 3'd4, 3'd4, 16'd1, 8'd2,  1'b1, 1'b0},  // R1 minimum limit, late
    '{2'd3, 3'd2, 3'd3, 16'd3, 8'd1,  1'b0, 1'b1}   // R4 single-bit ID difference
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tasks start at a falling edge and return at a falling edge.
  task automatic issue(input int ch, input int id);
    req_valid = 1'b1; req_ch = CH_W'(ch); req_id = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input int ch, input logic [HDR_W-1:0] hdr);
    rsp_valid = 1'b1; rsp_ch = CH_W'(ch); rsp_hdr = hdr;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic clear_all();
    clr_tmo = '1; clr_ide = '1;
    @(negedge clk);
    clr_tmo = '0; clr_ide = '0;
  endtask

  task automatic set_limit(input int ch, input int lim);
    tmo_limit[ch*CNT_W +: CNT_W] = CNT_W'(lim);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [HDR_W-1:0] h;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: state after reset
    chk("R9 tmo_flag after reset", int'(tmo_flag), 0);
    chk("R9 ide_flag after reset", int'(ide_flag), 0);
    chk("R9 irq after reset", int'(irq), 0);
    chk("R9 fwd_valid after reset", int'(fwd_valid), 0);

    // R5: disabled block ignores a request
    set_limit(0, 2);
    issue(0, 1);
    repeat (5) @(negedge clk);
    chk("R5 no timeout while disabled", int'(tmo_flag[0]), 0);
    respond(0, {3'd6, 13'h0123});
    chk("R5 ignored request stores no ID", int'(ide_flag[0]), 0);
    chk("R3 response forwarded when idle", int'(fwd_valid), 1);
    chk("R3 forwarded header when idle", int'(fwd_hdr), int'({3'd6, 13'h0123}));
    enable = 1'b1;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      set_limit(VECS[v].ch, VECS[v].lim);
      clear_all();
      issue(VECS[v].ch, VECS[v].id);
      repeat (VECS[v].dly - 1) @(negedge clk);
      h = {VECS[v].rid, 13'(v * 37 + 5)};
      respond(VECS[v].ch, h);
      chk($sformatf("R3 fwd_valid vec%0d", v), int'(fwd_valid), 1);
      chk($sformatf("R3 fwd_hdr vec%0d", v), int'(fwd_hdr), int'(h));
      chk($sformatf("R3 fwd_ch vec%0d", v), int'(fwd_ch), int'(VECS[v].ch));
      chk($sformatf("R1 tmo_flag vec%0d", v), int'(tmo_flag[VECS[v].ch]), int'(VECS[v].etmo));
      chk($sformatf("R4 ide_flag vec%0d", v), int'(ide_flag[VECS[v].ch]), int'(VECS[v].eide));
      repeat (VECS[v].lim + 3) @(negedge clk);
      chk($sformatf("R1 tmo_flag settled vec%0d", v), int'(tmo_flag[VECS[v].ch]), int'(VECS[v].etmo));
    end
    clear_all();

    // R6: second request to a busy channel keeps the first ID
    set_limit(1, 0);
    issue(1, 2);
    issue(1, 5);
    respond(1, {3'd2, 13'h0042});
    chk("R6 first ID kept", int'(ide_flag[1]), 0);
    respond(1, {3'd7, 13'h0043});
    chk("R4 idle channel not checked", int'(ide_flag[1]), 0);

    // R6: counter not restarted by a refused request
    set_limit(1, 3);
    issue(1, 0);
    @(negedge clk);
    issue(1, 1);
    @(negedge clk);
    chk("R6 timer not restarted", int'(tmo_flag[1]), 1);
    respond(1, {3'd0, 13'h0001});
    clear_all();

    // R7 / R8: masking, selective clear, interrupt tracking
    set_limit(2, 2); set_limit(3, 2);
    issue(2, 0);
    issue(3, 0);
    repeat (3) @(negedge clk);
    chk("R1 ch2 timed out", int'(tmo_flag[2]), 1);
    chk("R1 ch3 timed out", int'(tmo_flag[3]), 1);
    chk("R8 irq masked", int'(irq), 0);
    tmo_ie[3] = 1'b1;
    @(negedge clk);
    chk("R8 irq raised", int'(irq), 1);
    clr_tmo[3] = 1'b1;
    @(negedge clk);
    clr_tmo[3] = 1'b0;
    chk("R7 ch3 cleared", int'(tmo_flag[3]), 0);
    chk("R7 ch2 untouched", int'(tmo_flag[2]), 1);
    @(negedge clk);
    chk("R8 irq dropped", int'(irq), 0);
    respond(2, {3'd0, 13'h0002});
    respond(3, {3'd0, 13'h0003});
    chk("R7 late response leaves flag", int'(tmo_flag[3]), 0);
    tmo_ie = '0;
    clear_all();

    // R7: set beats clear in the same cycle; R8 through the ID enable
    set_limit(0, 0);
    issue(0, 1);
    rsp_valid = 1'b1; rsp_ch = 2'd0; rsp_hdr = {3'd4, 13'h0AAA};
    clr_ide[0] = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0; clr_ide[0] = 1'b0;
    chk("R7 set wins over clear", int'(ide_flag[0]), 1);
    ide_ie[0] = 1'b1;
    @(negedge clk);
    chk("R8 irq from ID error", int'(irq), 1);
    ide_ie = '0;
    clear_all();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule